// File: doc/BRIEF.md
# Programmable Delay Address Interface

This block holds the address that selects the tap of a programmable delay line and gives a host three ways to set it. It has one mode pin and one enable pin. In parallel mode the enable either passes the parallel bus straight through to the active address or, when it is pulsed, captures the bus as it falls. In serial mode the enable frames a transfer. During that transfer the serial clock shifts data into a holding register, and the fall of the enable commits the register to the active address.

Serial transfers are full duplex. As each new bit enters at the least significant end, the old register contents leave on the serial output, top bit first. The output of one device can therefore feed the input of the next to form a chain, with eight bits per device. Reading empties the register. A host that wants to keep the setting shifts the bits it reads back in before it drops the enable. The serial output drive is enabled only while a serial frame is open.

Every input is brought into the system clock domain through a synchronizer, and the edges of the enable and the serial clock are detected in that domain. The interface is strobe based and has no back-pressure: the host must space its serial clock edges and enable changes several system clock cycles apart. No valid/ready handshake applies.

Top module: `dly_prog_if`

## Requirements
- R1: After reset the active address is 0, the serial output drive is disabled, and the holding register is 0, so the first bit read in a serial frame is 0.
- R2: With mode high (parallel) and enable high, the active address follows the parallel bus.
- R3: With mode high and enable low, changes on the parallel bus leave the active address unchanged. A falling enable loads the bus value present at that fall.
- R4: With mode low (serial), a falling enable copies the holding register into the active address.
- R5: With mode low and enable high, each rising serial clock shifts the holding register left by one and takes serial data into bit 0. The serial output shows bit 7 of the register, so a frame of eight clocks returns the old contents most significant bit first.
- R6: A frame that shifts back the eight bits it reads leaves the active address unchanged after enable falls.
- R7: The serial output drive enable is high exactly while mode is low and enable is high. It is low in parallel mode.
- R8: Serial clock edges while enable is low leave the holding register unchanged.
- R9: While a serial frame is open, shifting does not change the active address.
- R10: Serial clock edges in parallel mode leave the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = parallel programming, 0 = serial programming |
| en_i | input | 1 | Address enable: pass gate, load strobe or serial frame |
| sclk_i | input | 1 | Serial shift clock, sampled by clk |
| sdi_i | input | 1 | Serial data in |
| par_i | input | WIDTH | Parallel address bus |
| sdo_o | output | 1 | Serial data out (holding register MSB) |
| sdo_oe_o | output | 1 | Drive enable for the serial output pad |
| delay_o | output | WIDTH | Active delay address |

## Verification
The hardest state to reach from the ports is a holding register whose contents differ from the active address. Reaching it takes serial clocks while the enable is low or while the block is in parallel mode, followed by a read that shows the register survived. The stimulus first loads a known byte, then issues stray serial clocks in both of those conditions. It then opens a frame and reads all eight bits while writing them back. Destructive reads are checked the same way: a frame writes back exactly the bits it read, and the bench confirms that both the active address and a later read are unchanged.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;

  typedef enum logic {
    PGM_SERIAL   = 1'b0,
    PGM_PARALLEL = 1'b1
  } pgm_mode_e;

  // number of single-bit control pins carried beside the parallel bus
  localparam int CTL_PINS = 4;

endpackage

// File: rtl/dly_sync_bus.sv
module dly_sync_bus #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES == 1) begin : g_one
      logic flop;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop <= 1'b0;
        else        flop <= d_i[b];
      end
      assign q_o[b] = flop;
    end else begin : g_many
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
    end
  end

endmodule

// File: rtl/dly_edge_det.sv
module dly_edge_det #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
    assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
  end

endmodule

// File: rtl/dly_shift_reg.sv
module dly_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_i,
  input  logic             sdi_i,
  output logic [WIDTH-1:0] sr_o,
  output logic             sdo_o
);

  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], sdi_i};
  end

  assign sr_o  = sr_q;
  assign sdo_o = sr_q[WIDTH-1];

endmodule

// File: rtl/dly_active_reg.sv
module dly_active_reg
  import dly_prog_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pgm_mode_e        mode_i,
  input  logic             en_lvl_i,
  input  logic             en_fall_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic [WIDTH-1:0] sr_i,
  output logic [WIDTH-1:0] act_o
);

  logic             take_par;
  logic             take_ser;
  logic [WIDTH-1:0] act_q;
  logic [WIDTH-1:0] act_d;

  always_comb begin
    take_par = (mode_i == PGM_PARALLEL) && (en_lvl_i || en_fall_i);
    take_ser = (mode_i == PGM_SERIAL) && en_fall_i;
    act_d    = act_q;
    if (take_par)      act_d = par_i;
    else if (take_ser) act_d = sr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign act_o = act_q;

endmodule

// File: rtl/dly_prog_if.sv
module dly_prog_if
  import dly_prog_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             en_i,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [WIDTH-1:0] delay_o
);

  localparam int BUS_W = WIDTH + CTL_PINS;

  logic [BUS_W-1:0] raw_bus;
  logic [BUS_W-1:0] syn_bus;
  logic             mode_s;
  logic             en_s;
  logic             sclk_s;
  logic             sdi_s;
  logic [WIDTH-1:0] par_s;
  logic [1:0]       rise_v;
  logic [1:0]       fall_v;
  logic             sclk_rise;
  logic             en_fall;
  logic             shift_go;
  logic             serial_open;
  logic [WIDTH-1:0] sr_q;
  pgm_mode_e        mode_e;

  assign raw_bus = {par_i, sdi_i, sclk_i, en_i, mode_i};

  dly_sync_bus #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (syn_bus)
  );

  assign mode_s = syn_bus[0];
  assign en_s   = syn_bus[1];
  assign sclk_s = syn_bus[2];
  assign sdi_s  = syn_bus[3];
  assign par_s  = syn_bus[BUS_W-1:CTL_PINS];
  assign mode_e = pgm_mode_e'(mode_s);

  dly_edge_det #(.WIDTH(2)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({en_s, sclk_s}),
    .rise_o (rise_v),
    .fall_o (fall_v)
  );

  assign sclk_rise   = rise_v[0];
  assign en_fall     = fall_v[1];
  assign serial_open = en_s && (mode_e == PGM_SERIAL);
  assign shift_go    = serial_open && sclk_rise;

  dly_shift_reg #(.WIDTH(WIDTH)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_go),
    .sdi_i   (sdi_s),
    .sr_o    (sr_q),
    .sdo_o   (sdo_o)
  );

  dly_active_reg #(.WIDTH(WIDTH)) u_active (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_e),
    .en_lvl_i  (en_s),
    .en_fall_i (en_fall),
    .par_i     (par_s),
    .sr_i      (sr_q),
    .act_o     (delay_o)
  );

  assign sdo_oe_o = serial_open;

endmodule

// File: rtl/dly_prog_chk.sv
module dly_prog_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_s,
  input logic             mode_s,
  input logic             sclk_rise,
  input logic             en_fall,
  input logic [WIDTH-1:0] par_s,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] delay_o,
  input logic             sdo_o,
  input logic             sdo_oe_o
);

  assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && mode_s) |=> (delay_o == $past(par_s)));

  assert_latch_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && mode_s) |=> (delay_o == $past(par_s)));

  assert_serial_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !mode_s) |=> (delay_o == $past(sr_q)));

  assert_msb_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && en_s && !mode_s) |=> (sdo_o == $past(sr_q[WIDTH-2])));

  assert_hiz_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s || mode_s) |-> !sdo_oe_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(sr_q));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_fall && !(en_s && mode_s)) |=> $stable(delay_o));

  assert_par_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |=> $stable(sr_q));

endmodule

bind dly_prog_if dly_prog_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_s      (en_s),
  .mode_s    (mode_s),
  .sclk_rise (sclk_rise),
  .en_fall   (en_fall),
  .par_s     (par_s),
  .sr_q      (sr_q),
  .delay_o   (delay_o),
  .sdo_o     (sdo_o),
  .sdo_oe_o  (sdo_oe_o)
);

// File: tb/tb_dly_prog_if.sv
`timescale 1ns/1ps
module tb_dly_prog_if;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_i = 1'b0;
  logic       en_i = 1'b0;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic [7:0] par_i = 8'h00;
  logic       sdo_o;
  logic       sdo_oe_o;
  logic [7:0] delay_o;

  always #2.5 clk = ~clk;

  dly_prog_if dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(en_i),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .par_i(par_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .delay_o(delay_o)
  );

  typedef struct {
    int         kind;   // 0 delay, 1 sdo, 2 oe
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        case (e.kind)
          0: act = delay_o;
          1: act = {7'd0, sdo_oe_o ? sdo_o : 1'bx};
          default: act = {7'd0, sdo_oe_o};
        endcase
        checks++;
        if (act !== e.val) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] v, input string tag);
    repeat (5) @(posedge clk);
    q.push_back('{kind, v, tag});
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic set_in(input logic m, input logic e);
    @(negedge clk);
    mode_i = m;
    en_i   = e;
  endtask

  task automatic put_par(input logic [7:0] v);
    @(negedge clk);
    par_i = v;
  endtask

  task automatic sbit(input logic b);
    @(negedge clk);
    sdi_i = b;
    repeat (3) @(negedge clk);
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // checks each old bit on sdo before shifting in the next new bit
  task automatic xfer(input logic [7:0] din, input logic [7:0] old, input string tag);
    for (int i = 7; i >= 0; i--) begin
      expect_item(1, {7'd0, old[i]}, tag);
      sbit(din[i]);
    end
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    expect_item(0, 8'h00, "R1 delay after reset");
    expect_item(2, 8'h00, "R1 oe after reset");
    set_in(0, 1);
    expect_item(2, 8'h01, "R7 oe in serial frame");
    xfer(8'hA5, 8'h00, "R1 R5 first read");
    expect_item(0, 8'h00, "R9 hold during frame");
    set_in(0, 0);
    expect_item(0, 8'hA5, "R4 serial commit");
    expect_item(2, 8'h00, "R7 oe off after frame");

    set_in(0, 1);
    xfer(8'h3C, 8'hA5, "R5 readback");
    expect_item(0, 8'hA5, "R9 hold after shifts");
    set_in(0, 0);
    expect_item(0, 8'h3C, "R4 second commit");

    set_in(0, 1);
    xfer(8'h3C, 8'h3C, "R6 read with write-back");
    set_in(0, 0);
    expect_item(0, 8'h3C, "R6 address kept");
    set_in(0, 1);
    xfer(8'h81, 8'h3C, "R6 register restored");
    set_in(0, 0);
    expect_item(0, 8'h81, "R4 third commit");

    sbit(1'b0);
    sbit(1'b0);
    sbit(1'b0);
    expect_item(0, 8'h81, "R8 address kept");
    set_in(0, 1);
    xfer(8'h81, 8'h81, "R8 register kept");
    set_in(0, 0);

    set_in(1, 0);
    put_par(8'h5A);
    expect_item(0, 8'h81, "R3 bus ignored with enable low");
    set_in(1, 1);
    expect_item(0, 8'h5A, "R2 transparent");
    expect_item(2, 8'h00, "R7 oe off in parallel");
    put_par(8'hC3);
    expect_item(0, 8'hC3, "R2 transparent follow");
    sbit(1'b0);
    sbit(1'b0);
    put_par(8'h77);
    set_in(1, 0);
    put_par(8'h22);
    expect_item(0, 8'h77, "R3 captured at fall");
    sbit(1'b0);
    sbit(1'b0);

    set_in(0, 0);
    expect_item(0, 8'h77, "R10 address after mode change");
    set_in(0, 1);
    xfer(8'h81, 8'h81, "R10 register kept in parallel mode");
    set_in(0, 0);
    expect_item(0, 8'h81, "R10 commit restored value");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule